// File: doc/BRIEF.md
# Gated fractional tick divider

This block sits in front of a peripheral's functional clock and produces a clock-enable tick stream whose average rate is the input clock rate multiplied by M/N. Software programs it through one 32-bit control word. The word holds a gate enable, a 15-bit numerator M, a 15-bit denominator N and an update strobe. M and N are first written into a shadow copy. The divider starts using them only after a write that sets the update strobe.

The divider runs a phase accumulator. Each enabled cycle it adds M to the accumulator. When the sum reaches N, it subtracts N and emits a tick. A zero denominator, or a numerator larger than the denominator, is treated as a 1:1 ratio, so no register value can make the divider divide by zero. The tick is a plain registered enable, not a stream, so it carries no valid/ready handshake. The register port is a plain write strobe plus a read-data bus that always shows the control word.

Top module: `frac_tick_div`

## Requirements
- R1: Control bit 0 is the gate. While it reads 0, tick_o stays 0 and the accumulator holds its value. Setting the gate back to 1 resumes ticking from the held phase.
- R2: M occupies bits 15:1 and N occupies bits 30:16 of the control word. rd_data_o returns the gate, the shadow M, the shadow N and the current update bit, in those same positions.
- R3: A write loads the shadow fields. The active M/N change only when the written word has bit 31 set. Bit 31 then reads 1 for exactly one cycle, during which the copy is pending. It reads 0 from the next cycle on. A write with bit 31 clear leaves the tick pattern unchanged.
- R4: In the cycle in which the shadow M/N are copied to the active ratio, the accumulator returns to 0 and tick_o is 0.
- R5: With 0 < N and M ≤ N and the gate set, tick_o is 1 in exactly floor(K·M/N) of the K cycles that follow the copy cycle.
- R6: If the active N is 0, or the active M is greater than N, and the gate is set, tick_o is 1 in every cycle.
- R7: After reset, rd_data_o reads 0x00010002 (M=1, N=1, gate 0, update 0), the active ratio is 1:1, and tick_o is 0.
- R8: With M = 0 and N > 0, no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Writes wr_data_i into the control word this cycle |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Current control word: gate, shadow M/N, update bit |
| tick_o | output | 1 | Registered clock-enable tick |

## Verification
A wrong accumulator value shows up as a tick count over a fixed window that differs from floor(K·M/N). The error appears within one ratio period after the copy. A missed or premature shadow copy changes the tick pattern in the first period after the write. A stuck update bit shows on rd_data_o bit 31 one cycle after the write. The tick counts are compared over a 30-cycle window for each ratio. Any phase slip therefore changes the count before the window closes.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;
  localparam int unsigned RATIO_W = 15;
  localparam int unsigned WORD_W  = 2 * RATIO_W + 2;

  typedef struct packed {
    logic               upd;
    logic [RATIO_W-1:0] n;
    logic [RATIO_W-1:0] m;
    logic               gate;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{upd: 1'b0, n: RATIO_W'(1), m: RATIO_W'(1), gate: 1'b0};
endpackage

// File: rtl/frdiv_ctrl_reg.sv
module frdiv_ctrl_reg
  import frdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output ctrl_t              shadow_o,
  output logic               load_o,
  output logic [RATIO_W-1:0] act_m_o,
  output logic [RATIO_W-1:0] act_n_o
);
  ctrl_t              shadow_q;
  logic [RATIO_W-1:0] act_m_q, act_n_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      shadow_q <= CTRL_RESET;
      act_m_q  <= RATIO_W'(1);
      act_n_q  <= RATIO_W'(1);
    end else begin
      if (shadow_q.upd) begin
        act_m_q <= shadow_q.m;
        act_n_q <= shadow_q.n;
      end
      if (wr_en_i) shadow_q <= ctrl_t'(wr_data_i);
      else if (shadow_q.upd) shadow_q.upd <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign load_o   = shadow_q.upd;
  assign act_m_o  = act_m_q;
  assign act_n_o  = act_n_q;

  // R3: update bit is visible for one cycle only
  a_r3_upd_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_q.upd && !(wr_en_i && wr_data_i[WORD_W-1])) |=> !shadow_q.upd);
  // R3: active ratio changes only through a pending update
  a_r3_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shadow_q.upd |=> ($stable(act_m_q) && $stable(act_n_q)));
endmodule

// File: rtl/frdiv_phase_acc.sv
module frdiv_phase_acc #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  logic         load_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic         tick_q;
  logic [W:0]   sum, diff;
  logic         bypass;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, m_i};
    diff   = sum - {1'b0, n_i};
    bypass = (n_i == '0) || (m_i > n_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!gate_i) begin
      tick_q <= 1'b0;
    end else if (bypass) begin
      acc_q  <= '0;
      tick_q <= 1'b1;
    end else if (sum >= {1'b0, n_i}) begin
      acc_q  <= diff[W-1:0];
      tick_q <= 1'b1;
    end else begin
      acc_q  <= sum[W-1:0];
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  a_r1_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> !tick_o);
  a_r1_gate_holds_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !load_i) |=> $stable(acc_q));
  a_r4_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q == '0 && !tick_o));
  a_r5_acc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i != '0 && m_i <= n_i) |-> (acc_q < n_i));
  a_r6_bypass_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !load_i && (n_i == '0 || m_i > n_i)) |=> tick_o);
  a_r8_zero_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !load_i && m_i == '0 && n_i != '0) |=> !tick_o);
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import frdiv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        tick_o
);
  ctrl_t              shadow;
  logic               load;
  logic [RATIO_W-1:0] act_m, act_n;

  frdiv_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .shadow_o  (shadow),
    .load_o    (load),
    .act_m_o   (act_m),
    .act_n_o   (act_n)
  );

  frdiv_phase_acc #(.W(RATIO_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (shadow.gate),
    .load_i (load),
    .m_i    (act_m),
    .n_i    (act_n),
    .tick_o (tick_o)
  );

  assign rd_data_o = shadow;

  // R2: read-back mirrors the most recent write one cycle later
  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == $past(wr_data_i)));
endmodule

// File: tb/frac_tick_div_tb.sv
`timescale 1ns/1ps
module frac_tick_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_tick_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .tick_o(tick)
  );

  localparam int NV = 11;
  localparam int WIN = 30;
  // M, N, expected ticks in WIN cycles
  localparam int VM [NV] = '{1, 1, 2, 3, 0, 5, 9, 7, 32767, 1, 16};
  localparam int VN [NV] = '{1, 3, 5, 7, 4, 0, 4, 7, 32767, 32767, 30};
  localparam int VE [NV] = '{30, 10, 12, 12, 0, 30, 30, 30, 30, 0, 16};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_ticks(input int k, output int cnt);
    cnt = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  task automatic run_ratio(input int m, input int n, input bit g, output int cnt);
    logic [31:0] w;
    w = {1'b1, n[14:0], m[14:0], g};
    wr(w);
    chk(rd_data[31] == 1'b1, "R3 update bit pending", int'(rd_data[31]), 1);
    chk(rd_data[30:16] == n[14:0] && rd_data[15:1] == m[14:0] && rd_data[0] == g,
        "R2 field readback", int'(rd_data), int'(w));
    @(posedge clk); @(negedge clk);
    chk(rd_data[31] == 1'b0, "R3 update bit cleared", int'(rd_data[31]), 0);
    chk(tick == 1'b0, "R4 copy cycle tick low", int'(tick), 0);
    count_ticks(WIN, cnt);
  endtask

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_data == 32'h0001_0002, "R7 reset readback", int'(rd_data), 32'h0001_0002);
    chk(tick == 1'b0, "R7 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    count_ticks(5, cnt);
    chk(cnt == 0, "R7 R1 gate off after reset", cnt, 0);

    for (int v = 0; v < NV; v++) begin
      run_ratio(VM[v], VN[v], 1'b1, cnt);
      if (VN[v] == 0 || VM[v] > VN[v])
        chk(cnt == VE[v], "R6 degenerate ratio", cnt, VE[v]);
      else if (VM[v] == 0)
        chk(cnt == VE[v], "R8 zero numerator", cnt, VE[v]);
      else
        chk(cnt == VE[v], "R5 tick count", cnt, VE[v]);
    end

    // R3: shadow write without update keeps 1:3
    run_ratio(1, 3, 1'b1, cnt);
    chk(cnt == 10, "R5 one-in-three", cnt, 10);
    wr({1'b0, 15'd1, 15'd1, 1'b1});
    chk(rd_data == {1'b0, 15'd1, 15'd1, 1'b1}, "R3 shadow readback", int'(rd_data), 32'h0001_0003);
    count_ticks(WIN, cnt);
    chk(cnt == 10, "R3 no update keeps ratio", cnt, 10);

    // R1: gate off stops ticks, gate on resumes
    wr({1'b0, 15'd1, 15'd1, 1'b0});
    count_ticks(20, cnt);
    chk(cnt == 0, "R1 gate off", cnt, 0);
    wr({1'b0, 15'd1, 15'd1, 1'b1});
    count_ticks(WIN, cnt);
    chk(cnt == 10, "R1 gate resumes ratio", cnt, 10);

    // R1: gated update still copies; ticks stay off
    run_ratio(1, 1, 1'b0, cnt);
    chk(cnt == 0, "R1 gate off after update", cnt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule